// File: doc/BRIEF.md
# Three-Wire Segment Display Command Receiver

This block sits between a host's three-wire serial port (an active-low select, a shift clock and a data line) and the control logic of a four-common, fifty-segment LCD controller. It oversamples the serial lines with the fast system clock, assembles bits into bytes and interprets each byte either as a configuration command or as display data. Commands update a set of configuration outputs that the waveform generator consumes. Display data is cut into 4-bit nibbles and written into an external 50-entry by 4-bit display RAM.

A transfer begins when select goes low. The first byte of a session is always a command. The top bit of every command byte says what follows it. A one means another command follows. A zero means that every later byte in the session is display data. Display data goes to an address pointer that advances by one per nibble and wraps back to zero past the last entry. When select is released, any nibble still incomplete is thrown away, and the next session starts again in command mode.

The RAM write port is a one-cycle strobe with address and data and no back-pressure. The RAM must accept every strobe. Strobes come at most once per four serial clocks, so they are never adjacent. The configuration outputs are plain levels.

Top module: `seg_cmd_rx`

## Requirements
- R1: While `sel_n` is high, clock and data activity is ignored and the bit count is held at zero, so no configuration output changes and no RAM write occurs.
- R2: Data is sampled on rising `sclk` edges, most significant bit first, and a byte is complete at the 8th rising edge. Each session begins in command mode, and releasing `sel_n` returns the block to command mode.
- R3: Bit 7 of a command byte set to 1 keeps command mode. Bit 7 set to 0 makes every later byte of the session display data, and the top bit of a data byte is not interpreted.
- R4: The command bits 6..0 are decoded as follows. `100abcd` sets `disp_on`=a, `frame_inv`=b and `pwr_mode`=cd. `101abcd` sets `bias_half`=a, `ext_clk_sel`=b and `frame_rate`=cd. `1110xab` sets `blink_rate`=ab. `11111ab` sets `all_on`=a and `all_off`=b. Every other pattern with bit 6 set, except software reset, changes nothing.
- R5: A command with bit 6 clear loads the address pointer from bits 5..0. A value above 49 loads 0 instead.
- R6: Each data byte gives two nibbles, bits 7..4 first and then bits 3..0. Each nibble is written to the current address, and the address then advances by one, wrapping from 49 to 0.
- R7: A nibble whose four bits have not all arrived when `sel_n` rises is discarded and produces no write.
- R8: Software reset (`110101x`) returns every configuration output to 0 and the address to 0. It issues no RAM write.
- R9: After `rst_n`, every configuration output is 0, the address pointer is 0 and `ram_we` is low.
- R10: `ram_we` is high for exactly one system clock per nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock |
| sdat | input | 1 | Serial data, MSB first |
| disp_on | output | 1 | Display enable |
| frame_inv | output | 1 | 1 = frame inversion, 0 = line inversion |
| pwr_mode | output | 2 | Drive power mode |
| bias_half | output | 1 | 1 = half bias, 0 = third bias |
| ext_clk_sel | output | 1 | 1 = external clock source |
| frame_rate | output | 2 | Frame rate select |
| blink_rate | output | 2 | Blink rate select, 0 = off |
| all_on | output | 1 | Force every pixel on |
| all_off | output | 1 | Force every pixel off |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_addr | output | 6 | RAM write address |
| ram_wdata | output | 4 | RAM write nibble |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a 50-entry RAM. These defaults put the wrap from address 49 to 0 within reach of a single two-byte burst that starts at 48. They also let the bench try the out-of-range boundary at exactly 50 and at 63. The shift clock is held for several system clocks on each phase, so that every serial edge survives the synchronizer. Select is also released two bits into a nibble, to show that the incomplete nibble is dropped.

// File: rtl/segrx_pkg.sv
package segrx_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef struct packed {
    logic       disp_on;
    logic       frame_inv;
    logic [1:0] pwr_mode;
    logic       bias_half;
    logic       ext_clk;
    logic [1:0] frame_rate;
    logic [1:0] blink;
    logic       all_on;
    logic       all_off;
  } seg_cfg_t;

  localparam seg_cfg_t CFG_DEFAULT = '0;

  // opcode prefixes on bits 6 downward
  localparam logic [2:0] OP_MODE  = 3'b100;
  localparam logic [2:0] OP_DISP  = 3'b101;
  localparam logic [5:0] OP_SWRST = 6'b110101;
  localparam logic [3:0] OP_BLINK = 4'b1110;
  localparam logic [4:0] OP_APIX  = 5'b11111;

endpackage

// File: rtl/segrx_sync.sv
module segrx_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= RST_VAL;
      else        stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/segrx_shift.sv
module segrx_shift
  import segrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic              nib_vld,
  output logic [NIB_W-1:0]  nib,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W     = $clog2(BYTE_W);
  localparam int NIB_CNT_W = $clog2(NIB_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_d;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt;
  logic              rise;

  assign rise = sclk_s & ~sclk_d & ~sel_s;
  assign nxt  = {shreg[BYTE_W-2:0], sdat_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      nib_vld  <= 1'b0;
      nib      <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      sclk_d   <= sclk_s;
      nib_vld  <= 1'b0;
      byte_vld <= 1'b0;
      if (sel_s) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= nxt;
        cnt   <= cnt + CNT_W'(1);
        if (&cnt[NIB_CNT_W-1:0]) begin
          nib_vld <= 1'b1;
          nib     <= nxt[NIB_W-1:0];
        end
        if (cnt == CNT_LAST) begin
          byte_vld <= 1'b1;
          byte_q   <= nxt;
        end
      end
    end
  end

  // R1: nothing is emitted once select is seen released
  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_s) && sel_s |-> !nib_vld && !byte_vld);

  // R2: a completed byte leaves the bit count back at zero
  a_r2_byte_at_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> cnt == '0);

  // R2: a byte boundary is also a nibble boundary
  a_r2_byte_with_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> nib_vld);
endmodule

// File: rtl/segrx_decode.sv
module segrx_decode
  import segrx_pkg::*;
#(
  parameter int RAM_DEPTH = 50,
  parameter int ADDR_W    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              nib_vld,
  input  logic [NIB_W-1:0]  nib,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  output seg_cfg_t          cfg_q,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [NIB_W-1:0]  ram_wdata
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(RAM_DEPTH - 1);
  localparam logic [5:0]        FLD_LAST  = 6'(RAM_DEPTH - 1);

  logic              data_mode;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] addr_load;
  logic              is_swrst;

  assign addr_inc  = (addr == ADDR_LAST) ? '0 : addr + ADDR_W'(1);
  assign addr_load = (byte_q[5:0] > FLD_LAST) ? '0 : byte_q[ADDR_W-1:0];
  assign is_swrst  = (byte_q[6:1] == OP_SWRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_mode <= 1'b0;
      addr      <= '0;
      cfg_q     <= CFG_DEFAULT;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      if (nib_vld && data_mode) begin
        ram_we    <= 1'b1;
        ram_addr  <= addr;
        ram_wdata <= nib;
        addr      <= addr_inc;
      end
      if (byte_vld && !data_mode) begin
        data_mode <= ~byte_q[7];
        if (!byte_q[6])
          addr <= addr_load;
        else if (byte_q[6:4] == OP_MODE)
          {cfg_q.disp_on, cfg_q.frame_inv, cfg_q.pwr_mode} <= byte_q[3:0];
        else if (byte_q[6:4] == OP_DISP)
          {cfg_q.bias_half, cfg_q.ext_clk, cfg_q.frame_rate} <= byte_q[3:0];
        else if (is_swrst) begin
          cfg_q <= CFG_DEFAULT;
          addr  <= '0;
        end else if (byte_q[6:3] == OP_BLINK)
          cfg_q.blink <= byte_q[1:0];
        else if (byte_q[6:2] == OP_APIX)
          {cfg_q.all_on, cfg_q.all_off} <= byte_q[1:0];
      end
      if (sel_s) data_mode <= 1'b0;
    end
  end

  // R5, R6: the pointer never leaves the RAM range
  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= ADDR_LAST);

  // R10: write strobe lasts a single cycle
  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  // R8: software reset leaves display off and pointer at zero
  a_r8_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !data_mode && is_swrst && !(nib_vld && data_mode)
    |=> !cfg_q.disp_on && addr == '0);

  // R3: no write ever comes while in command mode
  a_r3_no_write_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    nib_vld && !data_mode |=> !ram_we);
endmodule

// File: rtl/seg_cmd_rx.sv
module seg_cmd_rx
  import segrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 50,
  localparam int ADDR_W     = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdat,
  output logic              disp_on,
  output logic              frame_inv,
  output logic [1:0]        pwr_mode,
  output logic              bias_half,
  output logic              ext_clk_sel,
  output logic [1:0]        frame_rate,
  output logic [1:0]        blink_rate,
  output logic              all_on,
  output logic              all_off,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [NIB_W-1:0]  ram_wdata
);
  logic [2:0]        pins_s;
  logic              nib_vld;
  logic [NIB_W-1:0]  nib;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;
  seg_cfg_t          cfg;

  segrx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdat}), .q(pins_s));

  segrx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sel_s(pins_s[2]), .sclk_s(pins_s[1]),
    .sdat_s(pins_s[0]), .nib_vld(nib_vld), .nib(nib),
    .byte_vld(byte_vld), .byte_q(byte_q));

  segrx_decode #(.RAM_DEPTH(RAM_DEPTH), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_s(pins_s[2]), .nib_vld(nib_vld),
    .nib(nib), .byte_vld(byte_vld), .byte_q(byte_q), .cfg_q(cfg),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  assign disp_on     = cfg.disp_on;
  assign frame_inv   = cfg.frame_inv;
  assign pwr_mode    = cfg.pwr_mode;
  assign bias_half   = cfg.bias_half;
  assign ext_clk_sel = cfg.ext_clk;
  assign frame_rate  = cfg.frame_rate;
  assign blink_rate  = cfg.blink;
  assign all_on      = cfg.all_on;
  assign all_off     = cfg.all_off;

  // R9: outputs idle in the first cycle out of reset
  a_r9_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> !ram_we && !disp_on);
endmodule

// File: tb/sim_seg_cmd_rx.sv
module sim_seg_cmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic disp_on, frame_inv, bias_half, ext_clk_sel, all_on, all_off, ram_we;
  logic [1:0] pwr_mode, frame_rate, blink_rate;
  logic [5:0] ram_addr;
  logic [3:0] ram_wdata;

  int checks = 0, failures = 0, wr_cnt = 0, cycles = 0;
  logic [3:0] mem [64];
  logic done = 1'b0;

  always #10 clk = ~clk;

  seg_cmd_rx u0 (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdat(sdat),
    .disp_on(disp_on), .frame_inv(frame_inv), .pwr_mode(pwr_mode),
    .bias_half(bias_half), .ext_clk_sel(ext_clk_sel), .frame_rate(frame_rate),
    .blink_rate(blink_rate), .all_on(all_on), .all_off(all_off),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!done && cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] cfg_now();
    return {disp_on, frame_inv, pwr_mode, bias_half, ext_clk_sel,
            frame_rate, blink_rate, all_on, all_off};
  endfunction

  task automatic chk_cfg(input string req, input logic [11:0] exp);
    chk(cfg_now() === exp, req, "config", int'(cfg_now()), int'(exp));
  endtask

  task automatic chk_mem(input string req, input int a, input logic [3:0] exp);
    chk(mem[a] === exp, req, $sformatf("mem[%0d]", a), int'(mem[a]), int'(exp));
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    send_bits(v, 8);
  endtask

  task automatic cs_low();
    sel_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic cs_high();
    wait_clk(6);
    sel_n = 1'b1;
    wait_clk(8);
  endtask

  logic [11:0] exp_cfg;

  // R9: reset state
  task automatic t_reset();
    chk_cfg("R9", 12'h000);
    chk(ram_we === 1'b0, "R9", "ram_we", int'(ram_we), 0);
    chk(wr_cnt == 0, "R9", "writes", wr_cnt, 0);
  endtask

  // R4, R3: chained commands set each field
  task automatic t_config();
    cs_low();
    send_byte(8'hCF);
    send_byte(8'hDE);
    send_byte(8'hF1);
    send_byte(8'hFE);
    cs_high();
    exp_cfg = {1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 2'b10, 2'b01, 1'b1, 1'b0};
    chk_cfg("R4", exp_cfg);
    chk(wr_cnt == 0, "R3", "no writes in command chain", wr_cnt, 0);
  endtask

  // R4: reserved pattern changes nothing
  task automatic t_reserved();
    int w0 = wr_cnt;
    cs_low();
    send_byte(8'hE0);
    cs_high();
    chk_cfg("R4", exp_cfg);
    chk(wr_cnt == w0, "R4", "reserved writes", wr_cnt - w0, 0);
  endtask

  // R1: bytes with select high are ignored
  task automatic t_deselected();
    int w0 = wr_cnt;
    send_byte(8'h40);
    send_byte(8'hFF);
    wait_clk(8);
    chk_cfg("R1", exp_cfg);
    chk(wr_cnt == w0, "R1", "writes while deselected", wr_cnt - w0, 0);
  endtask

  // R5, R6, R3: address set then two data bytes
  task automatic t_data();
    int w0 = wr_cnt;
    cs_low();
    send_byte(8'h05);
    send_byte(8'hA3);
    send_byte(8'h5C);
    cs_high();
    chk_mem("R6", 5, 4'hA);
    chk_mem("R6", 6, 4'h3);
    chk_mem("R3", 7, 4'h5);
    chk_mem("R6", 8, 4'hC);
    chk(wr_cnt - w0 == 4, "R6", "write count", wr_cnt - w0, 4);
    chk_cfg("R3", exp_cfg);
  endtask

  // R6: wrap past the last address
  task automatic t_wrap();
    cs_low();
    send_byte(8'h30);
    send_byte(8'h12);
    send_byte(8'h34);
    cs_high();
    chk_mem("R6", 48, 4'h1);
    chk_mem("R6", 49, 4'h2);
    chk_mem("R6", 0, 4'h3);
    chk_mem("R6", 1, 4'h4);
  endtask

  // R5: out-of-range address loads 0
  task automatic t_range();
    cs_low();
    send_byte(8'h3F);
    send_byte(8'h9E);
    cs_high();
    chk_mem("R5", 0, 4'h9);
    chk_mem("R5", 1, 4'hE);
    cs_low();
    send_byte(8'h32);
    send_byte(8'h6D);
    cs_high();
    chk_mem("R5", 0, 4'h6);
    chk_mem("R5", 1, 4'hD);
  endtask

  // R7, R2: partial nibble dropped, next session in command mode
  task automatic t_partial();
    int w0 = wr_cnt;
    cs_low();
    send_byte(8'h0A);
    send_bits(8'h07, 4);
    send_bits(8'h03, 2);
    cs_high();
    chk_mem("R7", 10, 4'h7);
    chk(wr_cnt - w0 == 1, "R7", "writes after release", wr_cnt - w0, 1);
    w0 = wr_cnt;
    cs_low();
    send_byte(8'hC8);
    cs_high();
    exp_cfg = {1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 2'b10, 2'b01, 1'b1, 1'b0};
    chk_cfg("R2", exp_cfg);
    chk(wr_cnt == w0, "R2", "command after release", wr_cnt - w0, 0);
  endtask

  // R8: software reset
  task automatic t_swrst();
    int w0 = wr_cnt;
    cs_low();
    send_byte(8'h6A);
    wait_clk(8);
    chk_cfg("R8", 12'h000);
    chk(wr_cnt == w0, "R8", "reset writes", wr_cnt - w0, 0);
    send_byte(8'h77);
    cs_high();
    chk_mem("R8", 0, 4'h7);
    chk_mem("R8", 1, 4'h7);
    chk_mem("R8", 5, 4'hA);
    chk(wr_cnt - w0 == 2, "R8", "writes after reset", wr_cnt - w0, 2);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_config();
    t_reserved();
    t_deselected();
    t_data();
    t_wrap();
    t_range();
    t_partial();
    t_swrst();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule